// File: doc/BRIEF.md
# Raster Window Crop with Shadowed Settings

This block cuts a rectangular window out of a raster pixel stream. Each input pixel comes with a valid strobe, a start-of-frame flag on the first pixel of a frame, and an end-of-line flag on the last pixel of each line. Pixels inside the window leave the block one cycle later. Frame and line flags are rebuilt so that they mark the first and last pixels of the window rather than those of the input raster.

Software programs the column offset, row offset, window width, window height and two crop-mode bits through a small register port. Writes go to working registers only. The datapath follows a shadow copy of the settings. A control write loads that copy in one of two ways: either at once, or at the next input start-of-frame so that a frame is never cropped with mixed settings. Both mode bits clear means the stream passes through untouched. The shadow copy can be read back at its own addresses.

Top module: `vwc_top`

## Requirements
- R1: After reset the outputs are low, and every register address (0 to 9) reads zero.
- R2: Writes to address 1 (column offset), 2 (row offset), 3 (width) or 4 (height) change the working value read at that address. They leave the shadow copy, read at addresses 6 to 9 in the same order, and the cropping unchanged until an update is requested.
- R3: A control write (address 0) with bit 2 set copies the working window and the mode bits [1:0] of that same write into the shadow set at the clock edge. The pixels after that edge are cropped with the new set. If bit 3 is also set in that write, bit 3 is ignored.
- R4: A control write with bit 3 set, and bit 2 clear, arms a deferred load. The next input pixel that carries start-of-frame is cropped with the working set as it stands in that cycle, and that set is copied into the shadow. The pixels before that pixel keep the old shadow set, even those in the frame already under way.
- R5: Bits 2 and 3 of the control register always read zero. Address 5 reads the shadow mode bits.
- R6: With both shadow mode bits clear, every input pixel appears one cycle later with its data, start-of-frame flag and end-of-line flag unchanged.
- R7: With mode bit 0 (YUV) or bit 1 (RAW) set, a pixel is output one cycle later only if its column is in [offset, offset+width-1] and its row is in [row offset, row offset+height-1]. Columns and rows count from 0 at start-of-frame. A zero width or height outputs nothing.
- R8: While cropping, start-of-frame is set on the first output pixel of each frame, and end-of-line is set on the output pixel at column offset+width-1.
- R9: A window that runs past the right edge of the input ends at the input's last pixel of the line, and that output pixel carries end-of-line.
- R10: If an immediate update falls in the same cycle as an armed start-of-frame pixel, that pixel uses the working set from before the write. The shadow then holds the immediate copy, and the armed load is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address for writes and reads |
| cfg_wdata | input | DIM_W | Register write data |
| cfg_rdata | output | DIM_W | Register read data (combinational from cfg_addr) |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | Input pixel is first of frame |
| in_eol | input | 1 | Input pixel is last of line |
| in_data | input | DATA_W | Input pixel value |
| out_valid | output | 1 | Output pixel valid |
| out_sof | output | 1 | Output pixel is first of cropped frame |
| out_eol | output | 1 | Output pixel is last of cropped line |
| out_data | output | DATA_W | Output pixel value |

## Verification
A register write and a pixel can fall in the same cycle. The hardest case is an immediate-update control write that lands on the very start-of-frame pixel that an armed deferred load is waiting for. The bench arms a deferred load whose window drops that pixel, then drives the pixel and a pass-through immediate write in one cycle. It judges three things: the pixel must vanish, the rest of the frame must pass through, and a later frame start must leave the shadow row offset alone. That last point proves the armed load was cancelled.

// File: rtl/vwc_pkg.sv
package vwc_pkg;

  // register map (the bench and software decode these)
  localparam int ADR_CTRL      = 0;
  localparam int ADR_HOFF      = 1;
  localparam int ADR_VOFF      = 2;
  localparam int ADR_HSIZE     = 3;
  localparam int ADR_VSIZE     = 4;
  localparam int ADR_CTRL_SHD  = 5;
  localparam int ADR_HOFF_SHD  = 6;
  localparam int ADR_VOFF_SHD  = 7;
  localparam int ADR_HSIZE_SHD = 8;
  localparam int ADR_VSIZE_SHD = 9;

  // control bit positions
  localparam int BIT_YUV     = 0;
  localparam int BIT_RAW     = 1;
  localparam int BIT_UPD_NOW = 2;
  localparam int BIT_UPD_SOF = 3;

  localparam int POS_W = 16;

  // true when pos lies in [start, start+len-1]
  function automatic logic span_hit(input logic [POS_W-1:0] pos,
                                    input logic [POS_W-1:0] start,
                                    input logic [POS_W-1:0] len);
    logic [POS_W:0] stop;
    stop = {1'b0, start} + {1'b0, len};
    return (pos >= start) && ({1'b0, pos} < stop);
  endfunction

  // true when pos is the last element of a non-empty span
  function automatic logic span_last(input logic [POS_W-1:0] pos,
                                     input logic [POS_W-1:0] start,
                                     input logic [POS_W-1:0] len);
    logic [POS_W:0] last;
    last = {1'b0, start} + {1'b0, len} - 1'b1;
    return (len != '0) && ({1'b0, pos} == last);
  endfunction

endpackage

// File: rtl/vwc_regs.sv
module vwc_regs
  import vwc_pkg::*;
#(
  parameter int DIM_W  = 12,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DIM_W-1:0]  wr_data,
  output logic [DIM_W-1:0]  rd_data,
  input  logic              frame_start,
  output logic [DIM_W-1:0]  act_hoff,
  output logic [DIM_W-1:0]  act_voff,
  output logic [DIM_W-1:0]  act_hsize,
  output logic [DIM_W-1:0]  act_vsize,
  output logic [1:0]        act_mode,
  output logic [1:0]        shd_mode_o,
  output logic              upd_now_evt,
  output logic              load_sof_evt
);

  logic [DIM_W-1:0] wk_hoff, wk_voff, wk_hsize, wk_vsize;
  logic [1:0]       wk_mode;
  logic [DIM_W-1:0] sh_hoff, sh_voff, sh_hsize, sh_vsize;
  logic [1:0]       sh_mode;
  logic             armed;
  logic             wr_ctrl, arm_req;

  assign wr_ctrl      = wr_en && (addr == ADDR_W'(ADR_CTRL));
  assign upd_now_evt  = wr_ctrl && wr_data[BIT_UPD_NOW];
  assign arm_req      = wr_ctrl && wr_data[BIT_UPD_SOF] && !wr_data[BIT_UPD_NOW];
  assign load_sof_evt = armed && frame_start;

  // working registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wk_hoff  <= '0;
      wk_voff  <= '0;
      wk_hsize <= '0;
      wk_vsize <= '0;
      wk_mode  <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(ADR_HOFF))  wk_hoff  <= wr_data;
      if (addr == ADDR_W'(ADR_VOFF))  wk_voff  <= wr_data;
      if (addr == ADDR_W'(ADR_HSIZE)) wk_hsize <= wr_data;
      if (addr == ADDR_W'(ADR_VSIZE)) wk_vsize <= wr_data;
      if (addr == ADDR_W'(ADR_CTRL))  wk_mode  <= {wr_data[BIT_RAW], wr_data[BIT_YUV]};
    end
  end

  // deferred-load arm flag
  always_ff @(posedge clk) begin
    if (!rst_n)            armed <= 1'b0;
    else if (upd_now_evt)  armed <= 1'b0;
    else if (arm_req)      armed <= 1'b1;
    else if (load_sof_evt) armed <= 1'b0;
  end

  // shadow set: immediate copy wins over the frame-start copy
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_hoff  <= '0;
      sh_voff  <= '0;
      sh_hsize <= '0;
      sh_vsize <= '0;
      sh_mode  <= '0;
    end else if (upd_now_evt) begin
      sh_hoff  <= wk_hoff;
      sh_voff  <= wk_voff;
      sh_hsize <= wk_hsize;
      sh_vsize <= wk_vsize;
      sh_mode  <= {wr_data[BIT_RAW], wr_data[BIT_YUV]};
    end else if (load_sof_evt) begin
      sh_hoff  <= wk_hoff;
      sh_voff  <= wk_voff;
      sh_hsize <= wk_hsize;
      sh_vsize <= wk_vsize;
      sh_mode  <= wk_mode;
    end
  end

  // the frame-start pixel of an armed load already uses the working set
  always_comb begin
    if (load_sof_evt) begin
      act_hoff  = wk_hoff;
      act_voff  = wk_voff;
      act_hsize = wk_hsize;
      act_vsize = wk_vsize;
      act_mode  = wk_mode;
    end else begin
      act_hoff  = sh_hoff;
      act_voff  = sh_voff;
      act_hsize = sh_hsize;
      act_vsize = sh_vsize;
      act_mode  = sh_mode;
    end
  end

  assign shd_mode_o = sh_mode;

  always_comb begin
    rd_data = '0;
    case (addr)
      ADDR_W'(ADR_CTRL):      rd_data = DIM_W'(wk_mode);
      ADDR_W'(ADR_HOFF):      rd_data = wk_hoff;
      ADDR_W'(ADR_VOFF):      rd_data = wk_voff;
      ADDR_W'(ADR_HSIZE):     rd_data = wk_hsize;
      ADDR_W'(ADR_VSIZE):     rd_data = wk_vsize;
      ADDR_W'(ADR_CTRL_SHD):  rd_data = DIM_W'(sh_mode);
      ADDR_W'(ADR_HOFF_SHD):  rd_data = sh_hoff;
      ADDR_W'(ADR_VOFF_SHD):  rd_data = sh_voff;
      ADDR_W'(ADR_HSIZE_SHD): rd_data = sh_hsize;
      ADDR_W'(ADR_VSIZE_SHD): rd_data = sh_vsize;
      default:                rd_data = '0;
    endcase
  end

endmodule

// File: rtl/vwc_pos.sv
module vwc_pos #(
  parameter int DIM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eol,
  output logic [DIM_W-1:0] cur_col,
  output logic [DIM_W-1:0] cur_row
);

  logic [DIM_W-1:0] col_q, row_q;

  // position of the pixel presented this cycle
  assign cur_col = in_sof ? '0 : col_q;
  assign cur_row = in_sof ? '0 : row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (in_valid) begin
      if (in_eol) begin
        col_q <= '0;
        row_q <= cur_row + 1'b1;
      end else begin
        col_q <= cur_col + 1'b1;
        row_q <= cur_row;
      end
    end
  end

endmodule

// File: rtl/vwc_window.sv
module vwc_window
  import vwc_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int DIM_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eol,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DIM_W-1:0]  cur_col,
  input  logic [DIM_W-1:0]  cur_row,
  input  logic [DIM_W-1:0]  hoff,
  input  logic [DIM_W-1:0]  voff,
  input  logic [DIM_W-1:0]  hsize,
  input  logic [DIM_W-1:0]  vsize,
  input  logic [1:0]        mode,
  output logic              crop_on,
  output logic              pix_keep,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_eol,
  output logic [DATA_W-1:0] out_data
);

  logic hit, sof_mark, eol_mark, sof_pending;

  assign crop_on  = |mode;
  assign hit      = span_hit(POS_W'(cur_col), POS_W'(hoff), POS_W'(hsize)) &&
                    span_hit(POS_W'(cur_row), POS_W'(voff), POS_W'(vsize));
  assign pix_keep = in_valid && (crop_on ? hit : 1'b1);

  assign sof_mark = crop_on ? (in_sof || sof_pending) : in_sof;
  assign eol_mark = crop_on
                  ? (span_last(POS_W'(cur_col), POS_W'(hoff), POS_W'(hsize)) || in_eol)
                  : in_eol;

  // waits for the first kept pixel of a frame
  always_ff @(posedge clk) begin
    if (!rst_n)              sof_pending <= 1'b0;
    else if (in_valid) begin
      if (in_sof)            sof_pending <= !pix_keep;
      else if (pix_keep)     sof_pending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= pix_keep;
      out_sof   <= pix_keep && sof_mark;
      out_eol   <= pix_keep && eol_mark;
      out_data  <= pix_keep ? in_data : '0;
    end
  end

endmodule

// File: rtl/vwc_top.sv
module vwc_top #(
  parameter int DATA_W = 10,
  parameter int DIM_W  = 12,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DIM_W-1:0]  cfg_wdata,
  output logic [DIM_W-1:0]  cfg_rdata,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eol,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_eol,
  output logic [DATA_W-1:0] out_data
);

  logic [DIM_W-1:0] act_hoff, act_voff, act_hsize, act_vsize;
  logic [1:0]       act_mode, shd_mode;
  logic             upd_now_evt, load_sof_evt, crop_on, pix_keep;
  logic [DIM_W-1:0] cur_col, cur_row;
  logic             frame_start;

  assign frame_start = in_valid && in_sof;

  vwc_regs #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (cfg_wr),
    .addr         (cfg_addr),
    .wr_data      (cfg_wdata),
    .rd_data      (cfg_rdata),
    .frame_start  (frame_start),
    .act_hoff     (act_hoff),
    .act_voff     (act_voff),
    .act_hsize    (act_hsize),
    .act_vsize    (act_vsize),
    .act_mode     (act_mode),
    .shd_mode_o   (shd_mode),
    .upd_now_evt  (upd_now_evt),
    .load_sof_evt (load_sof_evt)
  );

  vwc_pos #(.DIM_W(DIM_W)) u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .in_eol   (in_eol),
    .cur_col  (cur_col),
    .cur_row  (cur_row)
  );

  vwc_window #(.DATA_W(DATA_W), .DIM_W(DIM_W)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_eol    (in_eol),
    .in_data   (in_data),
    .cur_col   (cur_col),
    .cur_row   (cur_row),
    .hoff      (act_hoff),
    .voff      (act_voff),
    .hsize     (act_hsize),
    .vsize     (act_vsize),
    .mode      (act_mode),
    .crop_on   (crop_on),
    .pix_keep  (pix_keep),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_eol   (out_eol),
    .out_data  (out_data)
  );

endmodule

// File: rtl/vwc_checks.sv
module vwc_checks
  import vwc_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [1:0]        wr_mode,
  input logic              wr_now,
  input logic [1:0]        rd_upd,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_sof,
  input logic              out_eol,
  input logic [DATA_W-1:0] out_data,
  input logic              crop_on,
  input logic [1:0]        shd_mode,
  input logic              upd_now_evt,
  input logic              load_sof_evt
);

  // R3: an immediate update lands the written mode bits in the shadow
  a_r3_now_loads_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == ADDR_W'(ADR_CTRL) && wr_now) |=> (shd_mode == $past(wr_mode)));

  // R4: without an update event the shadow mode holds
  a_r4_shadow_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_now_evt && !load_sof_evt) |=> $stable(shd_mode));

  // R5: update request bits never read back as set
  a_r5_upd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == ADDR_W'(ADR_CTRL)) |-> (rd_upd == 2'b00));

  // R6: pass-through copies the pixel one cycle later
  a_r6_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !crop_on) |=> (out_valid && out_data == $past(in_data)));

  // R7: no output without an input pixel the cycle before
  a_r7_out_from_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R8: markers only on valid output pixels
  a_r8_marks_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof || out_eol) |-> out_valid);

endmodule

bind vwc_top vwc_checks #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_wr       (cfg_wr),
  .cfg_addr     (cfg_addr),
  .wr_mode      (cfg_wdata[1:0]),
  .wr_now       (cfg_wdata[2]),
  .rd_upd       (cfg_rdata[3:2]),
  .in_valid     (in_valid),
  .in_data      (in_data),
  .out_valid    (out_valid),
  .out_sof      (out_sof),
  .out_eol      (out_eol),
  .out_data     (out_data),
  .crop_on      (crop_on),
  .shd_mode     (shd_mode),
  .upd_now_evt  (upd_now_evt),
  .load_sof_evt (load_sof_evt)
);

// File: tb/vwc_top_test.sv
module vwc_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 10;
  localparam int DIM_W  = 12;
  localparam int ADDR_W = 4;
  localparam int NVEC   = 6;
  // frame width, frame height, col offset, row offset, width, height, mode
  localparam int VEC [NVEC][7] = '{
    '{8, 6, 2, 1, 4, 3, 1},
    '{8, 6, 0, 0, 8, 6, 2},
    '{8, 6, 5, 3, 6, 5, 1},
    '{6, 4, 0, 0, 0, 2, 1},
    '{6, 4, 1, 1, 3, 2, 0},
    '{5, 5, 4, 4, 1, 1, 3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [DIM_W-1:0]  cfg_wdata = '0;
  logic [DIM_W-1:0]  cfg_rdata;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic out_valid, out_sof, out_eol;
  logic [DATA_W-1:0] out_data;

  int n_chk = 0, n_fail = 0, seed = 0;
  int e_hoff = 0, e_voff = 0, e_w = 0, e_h = 0;
  bit e_crop = 0, exp_pending = 0, finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vwc_top #(.DATA_W(DATA_W), .DIM_W(DIM_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
    .in_sof(in_sof), .in_eol(in_eol), .in_data(in_data),
    .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol), .out_data(out_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wr(input int a, input int d);
    cfg_wr = 1'b1; cfg_addr = ADDR_W'(a); cfg_wdata = DIM_W'(d);
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    cfg_addr = ADDR_W'(a);
    #1;
    d = int'(cfg_rdata);
  endtask

  task automatic set_exp(input int ho, input int vo, input int w, input int h, input int md);
    e_hoff = ho; e_voff = vo; e_w = w; e_h = h; e_crop = (md != 0);
  endtask

  // drive rows r0..r1 of a frame fw pixels wide and check every output pixel
  task automatic send_rows(input int fw, input int r0, input int r1,
                           input bit with_sof, input string tag);
    for (int r = r0; r <= r1; r++) begin
      for (int c = 0; c < fw; c++) begin
        logic [DATA_W-1:0] d;
        bit sp, keep, es, ee;
        logic [31:0] exp_v, act_v;
        d  = DATA_W'(r * 37 + c * 5 + seed);
        sp = with_sof && (r == r0) && (c == 0);
        in_valid = 1'b1; in_sof = sp; in_eol = (c == fw - 1); in_data = d;
        @(posedge clk); #1;
        if (e_crop) begin
          keep = (c >= e_hoff) && (c < e_hoff + e_w) && (r >= e_voff) && (r < e_voff + e_h);
          es = sp || exp_pending;
          ee = (c == e_hoff + e_w - 1) || (c == fw - 1);
        end else begin
          keep = 1'b1; es = sp; ee = (c == fw - 1);
        end
        if (sp) exp_pending = !keep;
        else if (keep) exp_pending = 1'b0;
        exp_v = {19'd0, keep, keep && es, keep && ee, keep ? d : {DATA_W{1'b0}}};
        act_v = {19'd0, out_valid, out_sof, out_eol, out_valid ? out_data : {DATA_W{1'b0}}};
        chk(tag, act_v, exp_v);
      end
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
    seed = seed + 11;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 outputs", {29'd0, out_valid, out_sof, out_eol}, 32'd0);
    for (int a = 0; a < 10; a++) begin
      rd(a, v);
      chk("R1 reg read", v, 0);
    end
    rst_n = 1'b1;
    @(posedge clk); #1;

    // table of windows, each loaded with an immediate update
    for (int i = 0; i < NVEC; i++) begin
      wr(1, VEC[i][2]); wr(2, VEC[i][3]); wr(3, VEC[i][4]); wr(4, VEC[i][5]);
      wr(0, VEC[i][6] | 4);
      set_exp(VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5], VEC[i][6]);
      send_rows(VEC[i][0], 0, VEC[i][1] - 1, 1'b1, VEC[i][6] == 0 ? "R6" : "R7 R8 R9");
      repeat (2) @(posedge clk); #1;
    end

    // R2: working write without update leaves the shadow and cropping alone
    wr(1, 0);
    rd(1, v); chk("R2 working read", v, 0);
    rd(6, v); chk("R2 shadow unchanged", v, 4);
    send_rows(5, 0, 4, 1'b1, "R2");

    // R4: deferred load armed mid-frame takes effect at the next frame
    send_rows(5, 0, 1, 1'b1, "R4 old frame head");
    wr(2, 0); wr(3, 2); wr(4, 2);
    wr(0, 1 | 8);
    rd(5, v); chk("R4 shadow mode before frame start", v, 3);
    rd(0, v); chk("R5 update bits read zero", v, 1);
    send_rows(5, 2, 4, 1'b0, "R4 old frame tail");
    set_exp(0, 0, 2, 2, 1);
    send_rows(5, 0, 4, 1'b1, "R4 new frame");
    rd(5, v); chk("R5 shadow mode", v, 1);
    rd(6, v); chk("R5 shadow col offset", v, 0);
    rd(8, v); chk("R5 shadow width", v, 2);
    rd(9, v); chk("R5 shadow height", v, 2);

    // R3: immediate update mid-frame
    send_rows(5, 0, 1, 1'b1, "R3 before");
    wr(1, 1); wr(2, 2); wr(3, 3); wr(4, 2);
    wr(0, 2 | 4);
    rd(0, v); chk("R5 ctrl after immediate", v, 2);
    set_exp(1, 2, 3, 2, 2);
    send_rows(5, 2, 4, 1'b0, "R3 after");

    // R10: immediate update on the armed frame-start pixel
    wr(1, 0); wr(2, 1); wr(3, 1); wr(4, 4);
    wr(0, 1 | 8);
    cfg_wr = 1'b1; cfg_addr = ADDR_W'(0); cfg_wdata = DIM_W'(4);
    in_valid = 1'b1; in_sof = 1'b1; in_eol = 1'b1; in_data = DATA_W'(9);
    @(posedge clk); #1;
    cfg_wr = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
    chk("R10 sof pixel uses armed set", {31'd0, out_valid}, 32'd0);
    set_exp(0, 0, 0, 0, 0);
    send_rows(1, 1, 3, 1'b0, "R10 rest passes");
    rd(5, v); chk("R10 shadow mode", v, 0);
    wr(2, 3);
    send_rows(1, 0, 1, 1'b1, "R10 next frame");
    rd(7, v); chk("R10 arm cancelled", v, 1);

    finished = 1;
    summary();
  end

endmodule